// File: doc/BRIEF.md
# Enable-Restarted Sampling Trigger Generator

This block produces a periodic sampling trigger from a fast reference clock, nominally 12 MHz. One trigger output feeds both the transmit and the receive sampling channels, so both channels always sample on the same edge. A period of 272 reference cycles gives about 44.1 kHz.

The trigger train is not free-running. An external cycle-enable input, which may arrive asynchronously, passes through a two-flop synchronizer. While the synchronized enable is low, the divider is held cleared and the trigger stays low. When it rises, counting starts from the cleared state, so the first trigger edge lands a fixed number of reference cycles after enable. That phase is the same on every enable cycle, to within one reference period. Gating a free-running trigger with enable does not give this: the phase offset then drifts from one cycle to the next. The period and high-time inputs are captured only while the block is idle.

A one-cycle `cycle_start_o` strobe marks the start of each enable cycle. A trigger count, cleared at that start, numbers the samples taken within the cycle.

Top module: `strig_gen`

## Requirements
- R1: After reset, and whenever the synchronized enable is low, `trig_o` is 0. When idle, the divider phase is cleared.
- R2: Let edge 0 be the first rising edge of `clk_i` that samples `en_i` high after an idle period of at least three cycles. `trig_o` (when `high_i` is nonzero) rises after edge 2, and this latency is identical on every enable cycle.
- R3: While enabled, `trig_o` repeats with a period of `period_i` cycles (`period_i` >= 2). It is high for the first `high_i` cycles of each period and low for the rest. If `high_i` >= `period_i`, it stays high.
- R4: With `high_i` = 0 the trigger never rises and the trigger count stays 0.
- R5: `period_i` and `high_i` are captured only while the synchronized enable is low. Changes made while enabled have no effect until the next enable cycle.
- R6: `cycle_start_o` is a single-cycle pulse that is high in exactly the first cycle of counting, the same cycle in which `trig_o` first goes high.
- R7: `trig_count_o` clears at each cycle start and increments by one on each rising edge of `trig_o`, counting that first edge. It holds its value while idle.
- R8: When `en_i` falls, `trig_o` follows the pattern of R3 for two more cycles and is then forced low after the edge 2 edges past the edge that first samples `en_i` low. No partial pulse continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Asynchronous cycle enable |
| period_i | input | PER_W | Trigger period in reference cycles |
| high_i | input | PER_W | Trigger high-time in reference cycles |
| trig_o | output | 1 | Sampling trigger shared by both channels |
| cycle_start_o | output | 1 | One-cycle strobe at the start of counting |
| trig_count_o | output | CNT_W | Trigger edges since the last cycle start |

## Verification
The assertions check these properties on every cycle: the trigger is forced low and the phase is cleared when idle, the captured period and high-time are frozen while enabled, the phase counter stays below the period, the start strobe lasts one cycle, and the trigger count clears on start and steps by one on each trigger edge. Some behaviours show only over a whole enable cycle, and the bench scenarios cover these. They include the fixed three-edge latency from enable and its repeatability across enable cycles with different idle gaps, and the full high/low waveform for several period and high-time pairs. They also include the two-cycle tail after enable falls and the final trigger count.

// File: rtl/strig_pkg.sv
`timescale 1ns/1ps
package strig_pkg;
  localparam int unsigned DEF_PER_W = 16;
  localparam int unsigned DEF_CNT_W = 16;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/strig_sync.sv
`timescale 1ns/1ps
module strig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else if (s == 0) sync_q[s] <= d_i;
        else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/strig_divider.sv
`timescale 1ns/1ps
module strig_divider #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] high_i,
  output logic             trig_o,
  output logic             start_o,
  output logic             start_evt_o,
  output logic             rise_evt_o
);
  logic [PER_W-1:0] per_q, high_q, cnt_q;
  logic             run_d_q, trig_q, start_q;
  logic             wrap;

  assign wrap        = (cnt_q == per_q - PER_W'(1));
  assign start_evt_o = run_i & ~run_d_q;
  // trigger goes high on this edge
  assign rise_evt_o  = run_i & (cnt_q == '0) & (high_q != '0) & ~trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q   <= '0;
      high_q  <= '0;
      cnt_q   <= '0;
      run_d_q <= 1'b0;
      trig_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      run_d_q <= run_i;
      start_q <= start_evt_o;
      if (!run_i) begin
        per_q  <= period_i;
        high_q <= high_i;
        cnt_q  <= '0;
        trig_q <= 1'b0;
      end else begin
        trig_q <= (cnt_q < high_q);
        cnt_q  <= wrap ? '0 : cnt_q + PER_W'(1);
      end
    end
  end

  assign trig_o  = trig_q;
  assign start_o = start_q;

  assert_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (!trig_q && cnt_q == '0));
  assert_cfg_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> ($stable(per_q) && $stable(high_q)));
  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && per_q > PER_W'(1)) |-> (cnt_q < per_q));
  assert_start_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);
endmodule

// File: rtl/strig_counter.sv
`timescale 1ns/1ps
module strig_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (start_i) cnt_q <= rise_i ? CNT_W'(1) : '0;
    else if (rise_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count_o = cnt_q;

  assert_clear_on_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q <= CNT_W'(1)));
  assert_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !start_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/strig_gen.sv
`timescale 1ns/1ps
module strig_gen
  import strig_pkg::*;
#(
  parameter int unsigned PER_W = DEF_PER_W,
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PER_W-1:0] period_i,
  input  logic [PER_W-1:0] high_i,
  output logic             trig_o,
  output logic             cycle_start_o,
  output logic [CNT_W-1:0] trig_count_o
);
  logic run, start_evt, rise_evt;

  strig_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (en_i),
    .q_o   (run)
  );

  strig_divider #(.PER_W(PER_W)) i_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .period_i   (period_i),
    .high_i     (high_i),
    .trig_o     (trig_o),
    .start_o    (cycle_start_o),
    .start_evt_o(start_evt),
    .rise_evt_o (rise_evt)
  );

  strig_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_evt),
    .rise_i (rise_evt),
    .count_o(trig_count_o)
  );
endmodule

// File: tb/test_strig_gen.sv
`timescale 1ns/1ps
module test_strig_gen;
  localparam int PER_W = 16;
  localparam int CNT_W = 16;
  localparam int NVEC  = 6;
  // period, high, idle gap before enable
  localparam int VEC_PER [NVEC] = '{272, 5, 7, 3, 4, 2};
  localparam int VEC_HI  [NVEC] = '{136, 2, 0, 3, 7, 1};
  localparam int VEC_GAP [NVEC] = '{4, 9, 5, 13, 6, 7};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [PER_W-1:0] period = '0;
  logic [PER_W-1:0] high = '0;
  logic             trig, cstart;
  logic [CNT_W-1:0] tcount;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  strig_gen #(.PER_W(PER_W), .CNT_W(CNT_W)) i_strig_gen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .en_i         (en),
    .period_i     (period),
    .high_i       (high),
    .trig_o       (trig),
    .cycle_start_o(cstart),
    .trig_count_o (tcount)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_trig(input int i, input int per, input int hi);
    return (hi > 0) && ((i % per) < hi);
  endfunction

  // one enable cycle of len counting cycles; config changed mid-run to np/nh
  task automatic run_seq(input int per, input int hi, input int len,
                         input int np, input int nh, input string tag);
    int rises = 0;
    bit prev = 1'b0;
    @(negedge clk);
    period = PER_W'(per);
    high   = PER_W'(hi);
    en     = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(trig == 1'b0, "R2", "trig before latency", int'(trig), 0);
    for (int i = 0; i < len + 3; i++) begin
      bit e;
      @(posedge clk);
      #1;
      e = (i < len + 2) ? exp_trig(i, per, hi) : 1'b0;
      if (i < len + 2 && e && !prev) rises++;
      prev = e;
      if (i == 0 && hi > 0)
        check(trig == 1'b1, "R2", "trig at latency", int'(trig), 1);
      else if (i >= len)
        check(trig == e, "R8", "trig after enable fall", int'(trig), int'(e));
      else
        check(trig == e, (hi == 0) ? "R4" : tag, "trig waveform", int'(trig), int'(e));
      check(cstart == (i == 0), "R6", "cycle_start", int'(cstart), int'(i == 0));
      @(negedge clk);
      if (i == 0) begin
        period = PER_W'(np);
        high   = PER_W'(nh);
      end
      if (i == len - 1) en = 1'b0;
    end
    check(int'(tcount) == rises, (hi == 0) ? "R4" : "R7", "trig count", int'(tcount), rises);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(trig == 1'b0, "R1", "reset trig", int'(trig), 0);
    check(cstart == 1'b0, "R6", "reset cycle_start", int'(cstart), 0);
    check(tcount == '0, "R7", "reset count", int'(tcount), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      int keep;
      repeat (VEC_GAP[v]) @(negedge clk);
      #1;
      check(trig == 1'b0, "R1", "idle trig", int'(trig), 0);
      keep = int'(tcount);
      run_seq(VEC_PER[v], VEC_HI[v], 2 * VEC_PER[v], VEC_PER[v], VEC_HI[v], "R3");
      keep = int'(tcount);
      repeat (5) @(negedge clk);
      check(int'(tcount) == keep, "R7", "count held idle", int'(tcount), keep);
      check(trig == 1'b0, "R1", "idle trig after run", int'(trig), 0);
    end

    // config changed while enabled is ignored, taken on next cycle
    repeat (4) @(negedge clk);
    run_seq(6, 3, 14, 10, 1, "R5");
    repeat (4) @(negedge clk);
    run_seq(10, 1, 12, 10, 1, "R5");

    // enable dropped mid high-time, re-enabled after short gap: same phase
    repeat (3) @(negedge clk);
    run_seq(8, 5, 3, 8, 5, "R3");
    repeat (3) @(negedge clk);
    run_seq(8, 5, 11, 8, 5, "R2");

    // async reset mid-run
    @(negedge clk);
    period = PER_W'(4);
    high   = PER_W'(4);
    en     = 1'b1;
    repeat (5) @(negedge clk);
    check(trig == 1'b1, "R3", "constant high before reset", int'(trig), 1);
    rst_n = 1'b0;
    #1;
    check(trig == 1'b0, "R1", "trig in reset", int'(trig), 0);
    check(tcount == '0, "R7", "count in reset", int'(tcount), 0);
    en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule